// File: doc/BRIEF.md
# External Interrupt Controller with Next-Line Offset

This block gathers a bank of level-sensitive external interrupt lines, each with its own enable bit, and turns them into one external request for the core. Its configuration port is a CSR-style register window: software reads the raw line states, reads and writes the enable array, and reads a "next line" value. Both line arrays are 32 bits wide and are reached 16 bits at a time through a window index. The next-line value is the winning line number times four, so a handler can add it straight to a vector-table base address.

When several enabled lines are asserted, the highest-numbered one wins. The core pulses a handler-entry strobe when it takes the external interrupt. The block then raises its preemption level to one above the winning line. From that point the taken line, and every line below it, stops requesting. Only higher-numbered lines can still raise a request. A handler-exit strobe restores the level that was in force before the most recent entry.

The block also produces a machine interrupt-pending view. Bit 11 is the external request and bit 7 echoes the timer input. The request to the core is that bit 11 gated by the external-interrupt enable and the global interrupt enable.

Top module: `eic_top`

## Requirements
- R1: After reset-low, every enable bit is 0 and the preemption level is 0. The next-line register reads 0x80000000, `ext_irq_o` is 0 and `mip_o` bit 11 is 0.
- R2: Reading window select 0 (pending array) returns the raw state of `irq_i`, whatever the enables hold.
  - Index 0 returns bits 15:0 and index 1 returns bits 31:16, in `csr_rdata_o[15:0]`, with bits 31:16 of the read data zero.
  - Writes to select 0 have no effect.
- R3: A write with select 1 (enable array) loads `csr_wdata_i` into the window chosen by `csr_idx_i` (index 0 covers bits 15:0, index 1 covers bits 31:16). The new value is visible from the next cycle, and the other window keeps its value. Reading select 1 returns the window in `csr_rdata_o[15:0]`.
- R4: A line is eligible when it is asserted, enabled, and its number is at least the preemption level. Reading select 2 returns the highest-numbered eligible line times four, in bits 6:2, with every other bit 0.
- R5: When no line is eligible, select 2 reads 0x80000000 and `mip_o` bit 11 is 0.
- R6: The next-line value and `mip_o` bit 11 follow `irq_i` combinationally, in the same cycle, with no register delay.
- R7: `mip_o` bit 11 is 1 exactly when some line is eligible, and `mip_o` bit 7 equals `timer_irq_i`. All other bits are 0.
- R8: `ext_irq_o` equals `mip_o` bit 11 AND `meie_i` AND `glb_ie_i`.
- R9: A `trap_enter_i` pulse while a line is eligible sets the preemption level to that line number plus one, from the next cycle. That line and all lower lines then stop requesting, while higher lines can still win. `mip_o` bit 7 is unaffected.
- R10: A `trap_exit_i` pulse without `trap_enter_i` restores the level that was in force before the last accepted entry. When both strobes arrive in the same cycle, entry takes precedence.
- R11: Enabling a line whose input is already asserted raises the request in the cycle after the write.
- R12: A `trap_enter_i` pulse while no line is eligible leaves the preemption level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 32 | Level-sensitive external interrupt lines |
| timer_irq_i | input | 1 | Timer interrupt level, echoed in the pending view |
| meie_i | input | 1 | External interrupt enable from the core |
| glb_ie_i | input | 1 | Global machine interrupt enable from the core |
| csr_sel_i | input | 2 | Register select: 0 pending, 1 enable, 2 next line |
| csr_idx_i | input | 1 | 16-bit window index for the array registers |
| csr_wen_i | input | 1 | Write strobe |
| csr_wdata_i | input | 16 | Write data for one window |
| csr_rdata_o | output | 32 | Combinational read data |
| trap_enter_i | input | 1 | Handler-entry strobe from the core |
| trap_exit_i | input | 1 | Handler-exit strobe from the core |
| mip_o | output | 32 | Machine interrupt-pending view (bits 11 and 7 used) |
| ext_irq_o | output | 1 | Gated external request to the core |

## Verification
A corrupted enable bit shows up in the cycle after its write: the enable window readback changes, and so does the next-line value whenever that line is asserted. A wrong preemption level shows up in the cycle after an entry or exit strobe. Either a line that should be masked keeps `mip_o` bit 11 high, or a higher line fails to preempt. The picker and the pending view are purely combinational, so priority or window-mapping faults appear within the same cycle that the inputs change. That is why the bench compares them on every stimulus step.

// File: rtl/eic_pkg.sv
// Package: shared register-select encoding and constants for the
// external interrupt controller. Assumes at most 32 lines.
package eic_pkg;
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_EN   = 2'd1,
        SEL_NEXT = 2'd2
    } csr_sel_e;

    localparam logic [31:0] NEXT_NONE = 32'h8000_0000;
endpackage

// File: rtl/eic_enable_bank.sv
// Module: per-line enable register array, written one window at a time.
// Assumes NUM_IRQ is a multiple of WIN_W. Clears on synchronous reset.
module eic_enable_bank #(
    parameter int NUM_IRQ = 32,
    parameter int WIN_W   = 16,
    parameter int IDX_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [WIN_W-1:0]   wdata_i,
    output logic [NUM_IRQ-1:0] en_o
);
    localparam int NUM_WIN = NUM_IRQ / WIN_W;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Load this window when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_o[w*WIN_W +: WIN_W] <= '0;
            else if (wr_i && (idx_i == IDX_W'(w)))
                en_o[w*WIN_W +: WIN_W] <= wdata_i;
        end
    end
endmodule

// File: rtl/eic_pick.sv
// Module: fixed-order picker. Returns the highest-numbered line that is
// asserted, enabled and not below the preemption level. Purely combinational.
module eic_pick #(
    parameter int NUM_IRQ = 32,
    parameter int LVL_W   = 6,
    parameter int LINE_W  = 5
) (
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] en_i,
    input  logic [LVL_W-1:0]   level_i,
    output logic               valid_o,
    output logic [LINE_W-1:0]  line_o
);
    // Ascending scan so that the last hit, the highest line, wins.
    always_comb begin
        valid_o = 1'b0;
        line_o  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_i[i] && en_i[i] && (LVL_W'(i) >= level_i)) begin
                valid_o = 1'b1;
                line_o  = LINE_W'(i);
            end
        end
    end
endmodule

// File: rtl/eic_preempt.sv
// Module: preemption level with a one-deep save slot. An accepted entry
// saves the current level and raises it above the taken line. An exit
// restores the saved level. Entry wins over exit in the same cycle.
module eic_preempt #(
    parameter int LVL_W  = 6,
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic              exit_i,
    input  logic              take_valid_i,
    input  logic [LINE_W-1:0] take_line_i,
    output logic [LVL_W-1:0]  level_o,
    output logic [LVL_W-1:0]  saved_o
);
    // Update the level and the save slot on entry and exit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= '0;
            saved_o <= '0;
        end else if (enter_i && take_valid_i) begin
            saved_o <= level_o;
            level_o <= LVL_W'(take_line_i) + LVL_W'(1);
        end else if (exit_i && !enter_i) begin
            level_o <= saved_o;
        end
    end
endmodule

// File: rtl/eic_top.sv
// Module: external interrupt controller top. Ties together the enable bank,
// the picker and the preemption level, and builds the CSR read mux and the
// pending view. Assumes NUM_IRQ <= 32 and is a multiple of WIN_W.
module eic_top #(
    parameter int NUM_IRQ = 32,
    parameter int WIN_W   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [31:0]  irq_i,
    input  logic         timer_irq_i,
    input  logic         meie_i,
    input  logic         glb_ie_i,
    input  logic [1:0]   csr_sel_i,
    input  logic [0:0]   csr_idx_i,
    input  logic         csr_wen_i,
    input  logic [15:0]  csr_wdata_i,
    output logic [31:0]  csr_rdata_o,
    input  logic         trap_enter_i,
    input  logic         trap_exit_i,
    output logic [31:0]  mip_o,
    output logic         ext_irq_o
);
    import eic_pkg::*;

    localparam int NUM_WIN = NUM_IRQ / WIN_W;
    localparam int IDX_W   = 1;
    localparam int LVL_W   = $clog2(NUM_IRQ + 1);
    localparam int LINE_W  = $clog2(NUM_IRQ);

    csr_sel_e            sel;
    logic [NUM_IRQ-1:0]  irq_vec;
    logic [NUM_IRQ-1:0]  en_vec;
    logic [LVL_W-1:0]    level;
    logic [LVL_W-1:0]    saved_level;
    logic                pick_valid;
    logic [LINE_W-1:0]   pick_line;
    logic                en_wr;
    logic [WIN_W-1:0]    pend_win;
    logic [WIN_W-1:0]    en_win;

    assign sel     = csr_sel_e'(csr_sel_i);
    assign irq_vec = irq_i[NUM_IRQ-1:0];
    assign en_wr   = csr_wen_i && (sel == SEL_EN);

    eic_enable_bank #(
        .NUM_IRQ(NUM_IRQ), .WIN_W(WIN_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .idx_i(csr_idx_i),
        .wdata_i(csr_wdata_i[WIN_W-1:0]), .en_o(en_vec)
    );

    eic_pick #(
        .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .LINE_W(LINE_W)
    ) u_pick (
        .irq_i(irq_vec), .en_i(en_vec), .level_i(level),
        .valid_o(pick_valid), .line_o(pick_line)
    );

    eic_preempt #(
        .LVL_W(LVL_W), .LINE_W(LINE_W)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .enter_i(trap_enter_i), .exit_i(trap_exit_i),
        .take_valid_i(pick_valid), .take_line_i(pick_line),
        .level_o(level), .saved_o(saved_level)
    );

    // Pick the addressed window of the pending and enable arrays.
    always_comb begin
        pend_win = '0;
        en_win   = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (csr_idx_i == IDX_W'(w)) begin
                pend_win = irq_vec[w*WIN_W +: WIN_W];
                en_win   = en_vec[w*WIN_W +: WIN_W];
            end
        end
    end

    // Read mux over the three registers.
    always_comb begin
        unique case (sel)
            SEL_PEND: csr_rdata_o = 32'(pend_win);
            SEL_EN:   csr_rdata_o = 32'(en_win);
            SEL_NEXT: csr_rdata_o = pick_valid ? (32'(pick_line) << 2) : NEXT_NONE;
            default:  csr_rdata_o = '0;
        endcase
    end

    // Pending view and gated core request.
    always_comb begin
        mip_o     = '0;
        mip_o[7]  = timer_irq_i;
        mip_o[11] = pick_valid;
    end
    assign ext_irq_o = pick_valid && meie_i && glb_ie_i;
endmodule

// File: rtl/eic_chk.sv
// Module: assertion checker for eic_top, attached by bind below.
module eic_chk #(
    parameter int NUM_IRQ = 32,
    parameter int WIN_W   = 16,
    parameter int LVL_W   = 6,
    parameter int LINE_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_vec,
    input logic [NUM_IRQ-1:0] en_vec,
    input logic [LVL_W-1:0]   level,
    input logic [LVL_W-1:0]   saved_level,
    input logic               pick_valid,
    input logic [LINE_W-1:0]  pick_line,
    input logic               trap_enter_i,
    input logic               trap_exit_i,
    input logic               csr_wen_i,
    input logic [1:0]         csr_sel_i,
    input logic [0:0]         csr_idx_i,
    input logic [15:0]        csr_wdata_i,
    input logic               meie_i,
    input logic               glb_ie_i,
    input logic               ext_irq_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_vec == '0) && (level == '0));

    // R3
    en_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen_i && csr_sel_i == 2'd1 && csr_idx_i == 1'b0)
        |=> en_vec[WIN_W-1:0] == $past(csr_wdata_i[WIN_W-1:0]));

    // R4
    pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> irq_vec[pick_line] && en_vec[pick_line]
                       && (LVL_W'(pick_line) >= level));

    // R4
    pick_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((irq_vec & en_vec) >> pick_line) == NUM_IRQ'(1));

    // R8
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq_o |-> pick_valid && meie_i && glb_ie_i);

    // R9
    enter_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter_i && pick_valid)
        |=> level == $past(LVL_W'(pick_line)) + LVL_W'(1));

    // R10
    exit_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_exit_i && !trap_enter_i) |=> level == $past(saved_level));

    // R12
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter_i && !pick_valid && !trap_exit_i) |=> $stable(level));
endmodule

bind eic_top eic_chk #(
    .NUM_IRQ(NUM_IRQ), .WIN_W(WIN_W), .LVL_W(LVL_W), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_vec(irq_vec), .en_vec(en_vec),
    .level(level), .saved_level(saved_level), .pick_valid(pick_valid),
    .pick_line(pick_line), .trap_enter_i(trap_enter_i),
    .trap_exit_i(trap_exit_i), .csr_wen_i(csr_wen_i), .csr_sel_i(csr_sel_i),
    .csr_idx_i(csr_idx_i), .csr_wdata_i(csr_wdata_i), .meie_i(meie_i),
    .glb_ie_i(glb_ie_i), .ext_irq_o(ext_irq_o)
);

// File: tb/test_eic_top.sv
module test_eic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        timer = 1'b0;
    logic        meie = 1'b1;
    logic        glb = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic [0:0]  idx = 1'b0;
    logic        wen = 1'b0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic        enter = 1'b0;
    logic        exitp = 1'b0;
    logic [31:0] mip;
    logic        ext_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] en_m = '0;
    int          lvl_m = 0;
    int          sav_m = 0;

    always #4 clk = ~clk;

    eic_top i_eic_top (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .timer_irq_i(timer),
        .meie_i(meie), .glb_ie_i(glb), .csr_sel_i(sel), .csr_idx_i(idx),
        .csr_wen_i(wen), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .trap_enter_i(enter), .trap_exit_i(exitp), .mip_o(mip),
        .ext_irq_o(ext_irq)
    );

    function automatic int best_line();
        int b = -1;
        for (int i = 0; i < 32; i++)
            if (irq[i] && en_m[i] && i >= lvl_m) b = i;
        return b;
    endfunction

    function automatic logic [31:0] exp_next();
        int b = best_line();
        return (b < 0) ? 32'h8000_0000 : 32'(b) * 32'd4;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic x, output logic [31:0] v);
        @(negedge clk);
        sel = s;
        idx = x;
        #1;
        v = rdata;
    endtask

    task automatic wr_win(input logic [1:0] s, input logic x, input logic [15:0] d);
        @(negedge clk);
        sel = s; idx = x; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic wr_en(input logic [31:0] v);
        wr_win(2'd1, 1'b0, v[15:0]);
        wr_win(2'd1, 1'b1, v[31:16]);
        en_m = v;
    endtask

    task automatic strobe(input logic e, input logic x);
        int b;
        @(negedge clk);
        b = best_line();
        enter = e; exitp = x;
        if (e && b >= 0) begin
            sav_m = lvl_m;
            lvl_m = b + 1;
        end else if (x && !e) begin
            lvl_m = sav_m;
        end
        @(negedge clk);
        enter = 1'b0; exitp = 1'b0;
    endtask

    // Compare next-line value, pending view and gated request against the model.
    task automatic check_out(input string req);
        logic [31:0] v;
        logic        vld;
        rd(2'd2, 1'b0, v);
        vld = (best_line() >= 0);
        check({req, " next"}, v, exp_next());
        check({req, " mip"}, mip, (32'(vld) << 11) | (32'(timer) << 7));
        check({req, " ext_irq"}, 32'(ext_irq), 32'(vld && meie && glb));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        // R1: reset with every line asserted; nothing is enabled yet.
        irq = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, 1'b0, v); check("R1 enable lo", v, 32'h0);
        rd(2'd1, 1'b1, v); check("R1 enable hi", v, 32'h0);
        check_out("R1");

        // R2: raw pending windows, independent of enables.
        rd(2'd0, 1'b0, v); check("R2 pend lo all", v, 32'h0000_FFFF);
        rd(2'd0, 1'b1, v); check("R2 pend hi all", v, 32'h0000_FFFF);
        for (int i = 0; i < 32; i++) begin
            irq = 32'h1 << i;
            rd(2'd0, 1'b0, v); check("R2 pend lo walk", v, {16'h0, irq[15:0]});
            rd(2'd0, 1'b1, v); check("R2 pend hi walk", v, {16'h0, irq[31:16]});
        end
        irq = 32'h1234_8765;
        wr_win(2'd0, 1'b0, 16'h0000);
        wr_win(2'd0, 1'b1, 16'hFFFF);
        rd(2'd0, 1'b0, v); check("R2 pend write ignored lo", v, 32'h0000_8765);
        rd(2'd0, 1'b1, v); check("R2 pend write ignored hi", v, 32'h0000_1234);

        // R3: window writes, other half kept.
        wr_win(2'd1, 1'b0, 16'hA5C3);
        rd(2'd1, 1'b0, v); check("R3 en lo", v, 32'h0000_A5C3);
        rd(2'd1, 1'b1, v); check("R3 en hi untouched", v, 32'h0);
        wr_win(2'd1, 1'b1, 16'h5A3C);
        rd(2'd1, 1'b0, v); check("R3 en lo kept", v, 32'h0000_A5C3);
        rd(2'd1, 1'b1, v); check("R3 en hi", v, 32'h0000_5A3C);
        en_m = 32'h5A3C_A5C3;
        check_out("R3 partial enables");

        // R4 R6 R7: every pair of asserted lines with all enabled.
        wr_en(32'hFFFF_FFFF);
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge clk);
                sel = 2'd2;
                irq = (32'h1 << a) | (32'h1 << b);
                #1;
                check("R4 R6 pair next", rdata, 32'((a > b) ? a : b) * 32'd4);
                check("R7 pair mip", mip, 32'h800);
            end
        end

        // R4: single enable against all asserted lines.
        irq = 32'hFFFF_FFFF;
        for (int i = 0; i < 32; i++) begin
            wr_en(32'h1 << i);
            check_out("R4 single enable");
        end

        // R5: enables cover no asserted line.
        irq = 32'h0000_FFFF;
        wr_en(32'hFFFF_0000);
        check_out("R5 none eligible");

        // R8: gating of the core request, plus timer echo for R7.
        wr_en(32'hFFFF_FFFF);
        irq = 32'h0000_0100;
        for (int g = 0; g < 8; g++) begin
            @(negedge clk);
            meie = g[0]; glb = g[1]; timer = g[2];
            check_out("R8 R7 gating");
        end
        meie = 1'b1; glb = 1'b1; timer = 1'b1;

        // R11 R9 R10: all lines pending, enable top-down, take, clear, return.
        wr_en(32'h0);
        irq = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) begin
            wr_en(en_m | (32'h1 << i));
            check_out("R11 enable asserted line");
            rd(2'd0, 1'b0, v); check("R2 pend lo sweep", v, {16'h0, irq[15:0]});
            rd(2'd0, 1'b1, v); check("R2 pend hi sweep", v, {16'h0, irq[31:16]});
            strobe(1'b1, 1'b0);
            check_out("R9 entry masks taken line");
            @(negedge clk);
            irq[i] = 1'b0;
            strobe(1'b0, 1'b1);
            check_out("R10 exit restores level");
        end

        // R9: higher line preempts, lower line masked.
        irq = 32'h0000_0400;
        strobe(1'b1, 1'b0);
        check_out("R9 taken line 10 masked");
        @(negedge clk); irq = 32'h0000_0420;
        check_out("R9 lower line masked");
        @(negedge clk); irq = 32'h0010_0420;
        check_out("R9 higher line preempts");

        // R12: entry with nothing eligible keeps level 11.
        @(negedge clk); irq = 32'h0000_0020;
        strobe(1'b1, 1'b0);
        check_out("R12 idle entry");
        @(negedge clk); irq = 32'h0000_1000;
        check_out("R12 level kept");

        // R10: entry wins over simultaneous exit, then plain exit.
        strobe(1'b1, 1'b1);
        check_out("R10 entry precedence");
        strobe(1'b0, 1'b1);
        check_out("R10 restore");
        @(negedge clk); irq = 32'h0000_0020;
        check_out("R10 low line after restore");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule